// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control unit of a multi-cycle processor datapath. A 4-bit state register steps each instruction through fetch and decode. It then follows one of several class-specific paths through execute, memory and write-back, and afterwards returns to fetch. Each state drives one fixed set of control points into the datapath. These are register load enables, an ALU operation select, the PC source, the memory strobes and the register-file write controls. The datapath applies each transfer on the clock edge that leaves the state.

Two inputs steer the sequence: the 6-bit opcode held in the instruction register and the datapath's operand-equality flag. Both are looked at only in the decode state. In every other state the next state is fixed and the outputs depend on the state alone. An opcode the block does not recognise still consumes a cycle that advances the PC by 4, so execution continues past it.

Top module: `mcc_ctrl_top`

## Requirements
- R1: While `rst` is high, every output enable and strobe is 0 in that same cycle. The clock edge that samples `rst` high puts `phase` at 4'h0. After `rst` falls, the first cycle is fetch.
- R2: In fetch (`phase` 4'h0), only `ir_en` and `mem_rd` are 1, and the next state is always decode (4'h1).
- R3: In decode (4'h1), only `a_en` and `b_en` are 1. The next state is chosen from `opcode`: 6'b000000 register-register goes to 4'h4, 6'b001101 OR-immediate to 4'h6, 6'b100011 load to 4'h8, 6'b101011 store to 4'hB, and 6'b000100 branch-if-equal to 4'h2 or 4'h3.
- R4: A branch moves to 4'h2 when `equal` is 1 in the decode cycle; there `pc_en`=1 and `pc_src`=1 (branch target). With `equal` 0 it moves to 4'h3; there `pc_en`=1 and `pc_src`=0 (PC+4).
- R5: Register-register: 4'h4 has `alu_op`=2'b10 (function field, A with B) and `r_en`=1. It is followed by 4'h5, which has `reg_wr`=1, `dst_rd`=1, `wsel_mem`=0 and `pc_en`=1.
- R6: OR-immediate: 4'h6 has `alu_op`=2'b01 (A OR zero-extended immediate) and `r_en`=1. It is followed by 4'h7, which has `reg_wr`=1, `dst_rd`=0, `wsel_mem`=0 and `pc_en`=1.
- R7: Load: 4'h8 has `alu_op`=2'b00 (A plus sign-extended immediate) and `r_en`=1. Next is 4'h9, with `m_en`=1 and `mem_rd`=1. Last is 4'hA, with `reg_wr`=1, `dst_rd`=0, `wsel_mem`=1 and `pc_en`=1.
- R8: Store: 4'hB has `alu_op`=2'b00 and `r_en`=1. It is followed by 4'hC, which has `mem_wr`=1 and `pc_en`=1.
- R9: Every state that asserts `pc_en` is followed by fetch. Counting fetch, instructions take these numbers of cycles: branch 3, register-register 4, OR-immediate 4, store 4, load 5.
- R10: An unrecognised opcode in decode leads to 4'h3 (PC+4, `pc_src`=0) and then to fetch, which takes 3 cycles in total.
- R11: Changes on `opcode` or `equal` outside the decode cycle alter neither the sequence nor the outputs. Any control field that a state does not use reads 0.
- R12: `mem_rd` and `mem_wr` are never 1 together, and `reg_wr` is never 1 together with `mem_wr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| equal | input | 1 | Operand equality flag from the datapath |
| ir_en | output | 1 | Instruction register load |
| a_en | output | 1 | Operand A register load |
| b_en | output | 1 | Operand B register load |
| alu_op | output | 2 | ALU operation: 00 add sign-ext imm, 01 OR zero-ext imm, 10 function field |
| r_en | output | 1 | ALU result register load |
| m_en | output | 1 | Memory data register load |
| pc_en | output | 1 | PC load |
| pc_src | output | 1 | PC source: 0 PC+4, 1 branch target |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| reg_wr | output | 1 | Register file write enable |
| dst_rd | output | 1 | Destination select: 1 rd field, 0 rt field |
| wsel_mem | output | 1 | Write data select: 1 memory data, 0 ALU result |
| phase | output | 4 | Current state code |

## Verification
Two events can land in the same cycle: a synchronous reset and a write-back state that is committing a register write and a PC update. The bench raises `rst` while a load sits in its final state 4'hA. In that same cycle it expects `reg_wr` and `pc_en` to read 0 with `phase` still at 4'hA, and one edge later it expects `phase` at 4'h0. The second overlap is a change of `opcode` and `equal` during an execute state. The bench changes both to branch values there and checks that the register-register path still finishes through 4'h5.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int OPC_W = 6;
    localparam int ST_W  = 4;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'b001101;
    localparam logic [OPC_W-1:0] OPC_LW    = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_SW    = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;

    typedef enum logic [ST_W-1:0] {
        ST_FETCH    = 4'h0,
        ST_DECODE   = 4'h1,
        ST_BR_TAKEN = 4'h2,
        ST_BR_SKIP  = 4'h3,
        ST_RT_EXEC  = 4'h4,
        ST_RT_WB    = 4'h5,
        ST_ORI_EXEC = 4'h6,
        ST_ORI_WB   = 4'h7,
        ST_LD_ADDR  = 4'h8,
        ST_LD_MEM   = 4'h9,
        ST_LD_WB    = 4'hA,
        ST_ST_ADDR  = 4'hB,
        ST_ST_MEM   = 4'hC
    } ctl_state_e;

    typedef enum logic [1:0] {
        ALU_ADD_SX = 2'b00,
        ALU_OR_ZX  = 2'b01,
        ALU_FUNCT  = 2'b10
    } alu_sel_e;

    typedef struct packed {
        logic     ir_en;
        logic     a_en;
        logic     b_en;
        alu_sel_e alu;
        logic     r_en;
        logic     m_en;
        logic     pc_en;
        logic     pc_src;
        logic     mem_rd;
        logic     mem_wr;
        logic     reg_wr;
        logic     dst_rd;
        logic     wsel_mem;
    } ctl_word_t;

    function automatic logic is_terminal(input ctl_state_e s);
        return (s == ST_BR_TAKEN) || (s == ST_BR_SKIP) || (s == ST_RT_WB) ||
               (s == ST_ORI_WB)   || (s == ST_LD_WB)   || (s == ST_ST_MEM);
    endfunction

endpackage

// File: rtl/mcc_seq_next.sv
module mcc_seq_next
    import mcc_pkg::*;
(
    input  ctl_state_e       cur,
    input  logic [OPC_W-1:0] opcode,
    input  logic             equal,
    output ctl_state_e       nxt
);
    ctl_state_e dec_target;

    // Class dispatch out of decode; anything unknown skips ahead by 4.
    always_comb begin
        case (opcode)
            OPC_RTYPE: dec_target = ST_RT_EXEC;
            OPC_ORI:   dec_target = ST_ORI_EXEC;
            OPC_LW:    dec_target = ST_LD_ADDR;
            OPC_SW:    dec_target = ST_ST_ADDR;
            OPC_BEQ:   dec_target = equal ? ST_BR_TAKEN : ST_BR_SKIP;
            default:   dec_target = ST_BR_SKIP;
        endcase
    end

    always_comb begin
        case (cur)
            ST_FETCH:    nxt = ST_DECODE;
            ST_DECODE:   nxt = dec_target;
            ST_RT_EXEC:  nxt = ST_RT_WB;
            ST_ORI_EXEC: nxt = ST_ORI_WB;
            ST_LD_ADDR:  nxt = ST_LD_MEM;
            ST_LD_MEM:   nxt = ST_LD_WB;
            ST_ST_ADDR:  nxt = ST_ST_MEM;
            default:     nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mcc_ctl_out.sv
module mcc_ctl_out
    import mcc_pkg::*;
(
    input  ctl_state_e cur,
    output ctl_word_t  ctl
);
    always_comb begin
        ctl = ctl_word_t'('0);
        case (cur)
            ST_FETCH: begin
                ctl.ir_en  = 1'b1;
                ctl.mem_rd = 1'b1;
            end
            ST_DECODE: begin
                ctl.a_en = 1'b1;
                ctl.b_en = 1'b1;
            end
            ST_BR_TAKEN: begin
                ctl.pc_en  = 1'b1;
                ctl.pc_src = 1'b1;
            end
            ST_BR_SKIP: ctl.pc_en = 1'b1;
            ST_RT_EXEC: begin
                ctl.alu  = ALU_FUNCT;
                ctl.r_en = 1'b1;
            end
            ST_RT_WB: begin
                ctl.reg_wr = 1'b1;
                ctl.dst_rd = 1'b1;
                ctl.pc_en  = 1'b1;
            end
            ST_ORI_EXEC: begin
                ctl.alu  = ALU_OR_ZX;
                ctl.r_en = 1'b1;
            end
            ST_ORI_WB: begin
                ctl.reg_wr = 1'b1;
                ctl.pc_en  = 1'b1;
            end
            ST_LD_ADDR, ST_ST_ADDR: begin
                ctl.alu  = ALU_ADD_SX;
                ctl.r_en = 1'b1;
            end
            ST_LD_MEM: begin
                ctl.m_en   = 1'b1;
                ctl.mem_rd = 1'b1;
            end
            ST_LD_WB: begin
                ctl.reg_wr   = 1'b1;
                ctl.wsel_mem = 1'b1;
                ctl.pc_en    = 1'b1;
            end
            ST_ST_MEM: begin
                ctl.mem_wr = 1'b1;
                ctl.pc_en  = 1'b1;
            end
            default: ctl = ctl_word_t'('0);
        endcase
    end
endmodule

// File: rtl/mcc_ctrl_top.sv
module mcc_ctrl_top
    import mcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  logic             equal,
    output logic             ir_en,
    output logic             a_en,
    output logic             b_en,
    output logic [1:0]       alu_op,
    output logic             r_en,
    output logic             m_en,
    output logic             pc_en,
    output logic             pc_src,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             reg_wr,
    output logic             dst_rd,
    output logic             wsel_mem,
    output logic [ST_W-1:0]  phase
);
    ctl_state_e state;
    ctl_state_e state_nxt;
    ctl_word_t  ctl_raw;
    ctl_word_t  ctl;

    mcc_seq_next u_next (
        .cur    (state),
        .opcode (opcode),
        .equal  (equal),
        .nxt    (state_nxt)
    );

    mcc_ctl_out u_out (
        .cur (state),
        .ctl (ctl_raw)
    );

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= state_nxt;
    end

    // Reset silences every strobe in the same cycle it is raised.
    assign ctl = rst ? ctl_word_t'('0) : ctl_raw;

    assign ir_en    = ctl.ir_en;
    assign a_en     = ctl.a_en;
    assign b_en     = ctl.b_en;
    assign alu_op   = ctl.alu;
    assign r_en     = ctl.r_en;
    assign m_en     = ctl.m_en;
    assign pc_en    = ctl.pc_en;
    assign pc_src   = ctl.pc_src;
    assign mem_rd   = ctl.mem_rd;
    assign mem_wr   = ctl.mem_wr;
    assign reg_wr   = ctl.reg_wr;
    assign dst_rd   = ctl.dst_rd;
    assign wsel_mem = ctl.wsel_mem;
    assign phase    = state;

    // R1
    rst_to_fetch_chk: assert property (@(posedge clk) rst |=> (state == ST_FETCH));

    // R2
    fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH) |=> (state == ST_DECODE));

    // R4
    beq_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE && opcode == OPC_BEQ && equal) |=> (state == ST_BR_TAKEN));

    // R5
    rtype_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RT_EXEC) |=> (state == ST_RT_WB));

    // R9
    pc_update_return_chk: assert property (@(posedge clk) disable iff (rst)
        pc_en |=> (state == ST_FETCH));

    // R9
    terminal_pc_chk: assert property (@(posedge clk) disable iff (rst)
        is_terminal(state) |-> pc_en);

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr) && !(reg_wr && mem_wr));

endmodule

// File: tb/sim_mcc_ctrl_top.sv
module sim_mcc_ctrl_top;
    import mcc_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'b0;
    logic       equal = 1'b0;
    logic       ir_en, a_en, b_en, r_en, m_en, pc_en, pc_src;
    logic       mem_rd, mem_wr, reg_wr, dst_rd, wsel_mem;
    logic [1:0] alu_op;
    logic [3:0] phase;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mcc_ctrl_top u0 (
        .clk(clk), .rst(rst), .opcode(opcode), .equal(equal),
        .ir_en(ir_en), .a_en(a_en), .b_en(b_en), .alu_op(alu_op),
        .r_en(r_en), .m_en(m_en), .pc_en(pc_en), .pc_src(pc_src),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .reg_wr(reg_wr),
        .dst_rd(dst_rd), .wsel_mem(wsel_mem), .phase(phase)
    );

    logic [13:0] ctl_vec;
    assign ctl_vec = {ir_en, a_en, b_en, alu_op, r_en, m_en, pc_en, pc_src,
                      mem_rd, mem_wr, reg_wr, dst_rd, wsel_mem};

    // Expected controls per state, bit order as ctl_vec.
    function automatic logic [13:0] exp_ctl(input logic [3:0] p);
        case (p)
            4'h0: return 14'b100_00_00_00_10000;
            4'h1: return 14'b011_00_00_00_00000;
            4'h2: return 14'b000_00_00_11_00000;
            4'h3: return 14'b000_00_00_10_00000;
            4'h4: return 14'b000_10_10_00_00000;
            4'h5: return 14'b000_00_00_10_00110;
            4'h6: return 14'b000_01_10_00_00000;
            4'h7: return 14'b000_00_00_10_00100;
            4'h8: return 14'b000_00_10_00_00000;
            4'h9: return 14'b000_00_01_00_10000;
            4'hA: return 14'b000_00_00_10_00101;
            4'hB: return 14'b000_00_10_00_00000;
            4'hC: return 14'b000_00_00_10_01000;
            default: return 14'b0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] p);
        case (p)
            4'h0: return "R2";
            4'h1: return "R3";
            4'h2, 4'h3: return "R4";
            4'h4, 4'h5: return "R5";
            4'h6, 4'h7: return "R6";
            4'h8, 4'h9, 4'hA: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [3:0] ep, input logic [13:0] ec);
        checks++;
        if (phase !== ep || ctl_vec !== ec) begin
            errors++;
            $display("FAIL %s phase/ctl actual=%h/%b expected=%h/%b", tag, phase, ctl_vec, ep, ec);
        end
        checks++;
        if ((mem_rd && mem_wr) || (reg_wr && mem_wr)) begin
            errors++;
            $display("FAIL R12 strobes actual=rd%b wr%b rw%b expected=exclusive", mem_rd, mem_wr, reg_wr);
        end
    endtask

    // {opcode, equal, length, state sequence (first nibble = fetch)}
    localparam logic [29:0] VEC [0:5] = '{
        {OPC_RTYPE, 1'b0, 3'd4, 20'h01450},
        {OPC_ORI,   1'b0, 3'd4, 20'h01670},
        {OPC_LW,    1'b1, 3'd5, 20'h0189A},
        {OPC_SW,    1'b1, 3'd4, 20'h01BC0},
        {OPC_BEQ,   1'b1, 3'd3, 20'h01200},
        {OPC_BEQ,   1'b0, 3'd3, 20'h01300}
    };

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=timeout expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        #1 chk("R1", 4'h0, 14'b0);
        rst = 1'b0;
        #1 chk("R1", 4'h0, exp_ctl(4'h0));

        for (int v = 0; v < 6; v++) begin
            logic [2:0]  len;
            logic [19:0] seq;
            opcode = VEC[v][29:24];
            equal  = VEC[v][23];
            len    = VEC[v][22:20];
            seq    = VEC[v][19:0];
            for (int k = 0; k < int'(len); k++) begin
                logic [3:0] p;
                p = seq[19-4*k -: 4];
                chk(tag_of(p), p, exp_ctl(p));
                @(negedge clk);
                #1;
            end
            // R9: cycle count ends back in fetch
            chk("R9", 4'h0, exp_ctl(4'h0));
        end

        // R10: unknown opcode takes the PC+4 state, then fetch
        opcode = 6'h3F;
        chk("R10", 4'h0, exp_ctl(4'h0)); @(negedge clk); #1;
        chk("R10", 4'h1, exp_ctl(4'h1)); @(negedge clk); #1;
        chk("R10", 4'h3, exp_ctl(4'h3)); @(negedge clk); #1;
        chk("R10", 4'h0, exp_ctl(4'h0));

        // R4: equal only counts in the decode cycle
        opcode = OPC_BEQ; equal = 1'b0;
        @(negedge clk); #1;
        equal = 1'b1;
        chk("R4", 4'h1, exp_ctl(4'h1)); @(negedge clk); #1;
        equal = 1'b0;
        chk("R4", 4'h2, exp_ctl(4'h2)); @(negedge clk); #1;
        chk("R4", 4'h0, exp_ctl(4'h0));

        // R11: inputs changed during execute have no effect
        opcode = OPC_RTYPE; equal = 1'b0;
        @(negedge clk); #1;
        @(negedge clk); #1;
        opcode = OPC_BEQ; equal = 1'b1;
        chk("R11", 4'h4, exp_ctl(4'h4)); @(negedge clk); #1;
        opcode = OPC_LW;
        chk("R11", 4'h5, exp_ctl(4'h5)); @(negedge clk); #1;
        chk("R11", 4'h0, exp_ctl(4'h0));

        // R1: reset raised during load write-back
        opcode = OPC_LW;
        repeat (4) begin @(negedge clk); #1; end
        chk("R7", 4'hA, exp_ctl(4'hA));
        rst = 1'b1;
        #1 chk("R1", 4'hA, 14'b0);
        @(negedge clk); #1;
        chk("R1", 4'h0, 14'b0);
        rst = 1'b0;
        #1 chk("R1", 4'h0, exp_ctl(4'h0));
        @(negedge clk); #1;
        chk("R1", 4'h1, exp_ctl(4'h1));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule